// File: doc/BRIEF.md
# Rectangle Copy Engine for a Packed 24-bit Framebuffer

The engine moves a rectangular picture, stored as one unbroken run of bytes, into a framebuffer that is 320 pixels wide and 240 rows tall, with three bytes per pixel. Software gives the picture's source address, the framebuffer base, the pixel position (column and row) and the picture size in pixels. The engine then copies it one 16-bit word at a time over a simple request/ready memory port.

Each word is first read from the source and then written to the destination. The source address goes up by two bytes for every word. The destination address is derived from the pixel position, with the column rounded down to an even value. The destination goes up by two bytes inside a row; at the end of each row it jumps over the part of the framebuffer row that the picture does not cover.

A transfer uses two steps. A source-arm strobe captures the configuration. A later destination-go strobe starts the copy, and it only does so if the source side is armed. A geometry that cannot be copied raises an error flag, and no memory access takes place. Software watches the run flag until it drops. A one-cycle completion pulse marks the end, and sticky done and error flags stay set until software clears them.

Top module: `rect_copy`

## Requirements
- R1: After reset, run, done, done_pulse, error and mem_req are all low.
- R2: A dst_go strobe while the source side is not armed is ignored: no memory request is made and run stays low.
- R3: The first destination write goes to dst_base + (x with bit 0 cleared)×3 + y×960, where 960 is the framebuffer row length in bytes.
- R4: Each destination row receives width×3/2 word writes, at byte addresses that step by 2.
- R5: After the last word of a row, the next write address is larger by (320 − width)×3 + 2, which places it at the start of the same columns one framebuffer row lower.
- R6: Source reads begin at src_base and step by 2 bytes for every word, with no gap between rows. A transfer makes height×width×3/2 reads in total.
- R7: Each written word is equal to the data returned for the read just before it. Read data is taken from mem_rdata in the cycle that follows the read's acceptance.
- R8: run rises in the cycle after a valid dst_go is accepted and falls in the cycle after the final write is accepted. In that same cycle done_pulse is high for exactly one clock, and done goes high and stays high.
- R9: A start is rejected in any of these cases: width×3 is odd, width is zero, height is zero, (x with bit 0 cleared) + width > 320, or y + height > 240. On rejection, error is set in the cycle after dst_go, no memory request is made, and run stays low.
- R10: status_clr clears done and error. If a completion occurs in the same cycle as status_clr, the completion wins and done is set.
- R11: While mem_req is high and mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold steady.
- R12: Reads and writes alternate. After a read is accepted, there is no request in the next cycle. After a write is accepted, the next request (if any) is a read. mem_we is 1 for writes and 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src_base | input | ADDR_W (32) | Source byte address |
| cfg_dst_base | input | ADDR_W (32) | Framebuffer base byte address |
| cfg_x | input | DIM_W (9) | Destination column in pixels |
| cfg_y | input | DIM_W (9) | Destination row |
| cfg_width | input | DIM_W (9) | Picture width in pixels |
| cfg_height | input | DIM_W (9) | Picture height in rows |
| src_arm | input | 1 | Captures the configuration and arms the source side |
| dst_go | input | 1 | Starts the transfer if the source side is armed |
| status_clr | input | 1 | Clears done and error |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W (32) | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read is accepted |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| run | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| done_pulse | output | 1 | One-cycle completion strobe |
| error | output | 1 | Sticky geometry-rejection flag |

## Verification
The case that matters is status_clr arriving in the same clock edge that accepts the final write, so that a clear and a completion reach the status flags together. The bench arranges this from its memory model: when it grants the last write, it raises status_clr for that same edge, with done still set from an earlier transfer. It then expects done_pulse, done = 1 and run = 0 one cycle later. Separate runs with a plain clear, made away from any completion, confirm that the clear itself works, so the collision test really shows the set taking priority.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;

    localparam int WORD_BYTES = 2;
    localparam int WORD_BITS  = WORD_BYTES * 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_WRITE = 2'd3
    } rc_state_e;

    // Geometry that cannot be copied with whole words or that leaves the frame.
    function automatic logic rect_invalid(input int x, input int y,
                                          input int w, input int h,
                                          input int cols, input int rows,
                                          input int pix_bytes);
        return (w == 0) || (h == 0) || (((w * pix_bytes) % 2) != 0) ||
               (((x / 2) * 2 + w) > cols) || ((y + h) > rows);
    endfunction

endpackage

// File: rtl/rcopy_walk.sv
module rcopy_walk
    import rcopy_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DIM_W     = 9,
    parameter int FB_COLS   = 320,
    parameter int PIX_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [DIM_W-1:0]  x,
    input  logic [DIM_W-1:0]  y,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              last
);
    localparam int ROW_BYTES = FB_COLS * PIX_BYTES;
    localparam int WCNT_W    = DIM_W + 1;
    localparam int PROD_W    = WCNT_W + 2;

    logic [WCNT_W-1:0] col_q, wpr_q, wpr_n;
    logic [DIM_W-1:0]  row_q, hgt_q;
    logic [ADDR_W-1:0] skip_q, skip_n, x_off, y_off;
    logic [PROD_W-1:0] w_bytes;
    logic [DIM_W-1:0]  x_even;
    logic              row_end;

    always_comb begin
        x_even  = x & {{(DIM_W-1){1'b1}}, 1'b0};
        x_off   = ADDR_W'(x_even) * ADDR_W'(PIX_BYTES);
        y_off   = ADDR_W'(y) * ADDR_W'(ROW_BYTES);
        w_bytes = PROD_W'(width) * PROD_W'(PIX_BYTES);
        wpr_n   = WCNT_W'(w_bytes >> 1);
        skip_n  = ADDR_W'(ROW_BYTES) - ADDR_W'(w_bytes) + ADDR_W'(WORD_BYTES);
    end

    assign row_end = (col_q == wpr_q - 1'b1);
    assign last    = row_end && (row_q == hgt_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_addr <= '0;
            dst_addr <= '0;
            col_q    <= '0;
            row_q    <= '0;
            wpr_q    <= '0;
            hgt_q    <= '0;
            skip_q   <= '0;
        end else if (load) begin
            src_addr <= src_base;
            dst_addr <= dst_base + x_off + y_off;
            col_q    <= '0;
            row_q    <= '0;
            wpr_q    <= wpr_n;
            hgt_q    <= height;
            skip_q   <= skip_n;
        end else if (step) begin
            src_addr <= src_addr + ADDR_W'(WORD_BYTES);
            if (row_end) begin
                col_q    <= '0;
                row_q    <= row_q + 1'b1;
                dst_addr <= dst_addr + skip_q;
            end else begin
                col_q    <= col_q + 1'b1;
                dst_addr <= dst_addr + ADDR_W'(WORD_BYTES);
            end
        end
    end

endmodule

// File: rtl/rcopy_flags.sv
module rcopy_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_done,
    input  logic set_err,
    input  logic clr,
    output logic done,
    output logic err,
    output logic pulse
);
    // Setting outranks clearing when both land on one edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            err   <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= set_done;
            if (set_done)  done <= 1'b1;
            else if (clr)  done <= 1'b0;
            if (set_err)   err  <= 1'b1;
            else if (clr)  err  <= 1'b0;
        end
    end

endmodule

// File: rtl/rect_copy.sv
module rect_copy
    import rcopy_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DIM_W     = 9,
    parameter int FB_COLS   = 320,
    parameter int FB_ROWS   = 240,
    parameter int PIX_BYTES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    cfg_src_base,
    input  logic [ADDR_W-1:0]    cfg_dst_base,
    input  logic [DIM_W-1:0]     cfg_x,
    input  logic [DIM_W-1:0]     cfg_y,
    input  logic [DIM_W-1:0]     cfg_width,
    input  logic [DIM_W-1:0]     cfg_height,
    input  logic                 src_arm,
    input  logic                 dst_go,
    input  logic                 status_clr,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_BITS-1:0] mem_wdata,
    input  logic [WORD_BITS-1:0] mem_rdata,
    input  logic                 mem_ready,
    output logic                 run,
    output logic                 done,
    output logic                 done_pulse,
    output logic                 error
);
    rc_state_e             st_q;
    logic                  armed_q;
    logic [ADDR_W-1:0]     src_q, dst_q, src_addr, dst_addr;
    logic [DIM_W-1:0]      x_q, y_q, w_q, h_q;
    logic [WORD_BITS-1:0]  data_q;
    logic                  bad, launch, load, set_err, step, last, set_done;

    assign bad      = rect_invalid(int'(x_q), int'(y_q), int'(w_q), int'(h_q),
                                   FB_COLS, FB_ROWS, PIX_BYTES);
    assign launch   = (st_q == ST_IDLE) && dst_go && armed_q;
    assign load     = launch && !bad;
    assign set_err  = launch && bad;
    assign step     = (st_q == ST_WRITE) && mem_ready;
    assign set_done = step && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            armed_q <= 1'b0;
            src_q   <= '0;
            dst_q   <= '0;
            x_q     <= '0;
            y_q     <= '0;
            w_q     <= '0;
            h_q     <= '0;
            data_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (launch) begin
                        armed_q <= 1'b0;
                        if (!bad) st_q <= ST_READ;
                    end else if (src_arm) begin
                        armed_q <= 1'b1;
                        src_q   <= cfg_src_base;
                        dst_q   <= cfg_dst_base;
                        x_q     <= cfg_x;
                        y_q     <= cfg_y;
                        w_q     <= cfg_width;
                        h_q     <= cfg_height;
                    end
                end
                ST_READ:  if (mem_ready) st_q <= ST_HOLD;
                ST_HOLD: begin
                    data_q <= mem_rdata;
                    st_q   <= ST_WRITE;
                end
                ST_WRITE: if (mem_ready) st_q <= last ? ST_IDLE : ST_READ;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    rcopy_walk #(
        .ADDR_W(ADDR_W), .DIM_W(DIM_W), .FB_COLS(FB_COLS), .PIX_BYTES(PIX_BYTES)
    ) u_walk (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .src_base(src_q), .dst_base(dst_q), .x(x_q), .y(y_q),
        .width(w_q), .height(h_q),
        .src_addr(src_addr), .dst_addr(dst_addr), .last(last)
    );

    rcopy_flags u_flags (
        .clk(clk), .rst(rst), .set_done(set_done), .set_err(set_err),
        .clr(status_clr), .done(done), .err(error), .pulse(done_pulse)
    );

    assign mem_req   = (st_q == ST_READ) || (st_q == ST_WRITE);
    assign mem_we    = (st_q == ST_WRITE);
    assign mem_addr  = (st_q == ST_WRITE) ? dst_addr : src_addr;
    assign mem_wdata = data_q;
    assign run       = (st_q != ST_IDLE);

endmodule

// File: rtl/rect_copy_chk.sv
module rect_copy_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              status_clr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              mem_ready,
    input logic              run,
    input logic              done,
    input logic              done_pulse,
    input logic              error
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                     $stable(mem_addr) && $stable(mem_wdata)));

    // R12
    rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready) |=> !mem_req);

    // R12
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready) |=> !mem_we);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !mem_req);

    // R9
    err_not_running_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> !run);

    // R8
    pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (done && !run && $past(run)));

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !status_clr) |=> done);

endmodule

bind rect_copy rect_copy_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .status_clr(status_clr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .run(run), .done(done), .done_pulse(done_pulse),
    .error(error)
);

// File: tb/rect_copy_test.sv
`timescale 1ns/1ps
module rect_copy_test;
    localparam int ROWB = 960;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_src_base = '0, cfg_dst_base = '0;
    logic [8:0]  cfg_x = '0, cfg_y = '0, cfg_width = '0, cfg_height = '0;
    logic        src_arm = 1'b0, dst_go = 1'b0, status_clr = 1'b0;
    logic        mem_req, mem_we, run, done, done_pulse, error;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    rect_copy uut (.*);

    always #2 clk = ~clk;

    // expectations written by the main flow, read by the monitor
    int  e_src, e_dst, e_x, e_y, e_wpr, e_total;
    bit  collide_en = 0, clr_cmd = 0;
    // counters: main, monitor
    int  nchk_a = 0, nfail_a = 0, nchk_b = 0, nfail_b = 0;
    int  rd_idx = 0, wr_idx = 0;
    bit  pend_pulse = 0;
    int  cyc = 0;

    function automatic logic [15:0] word_of(input logic [31:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    function automatic logic [31:0] exp_src(input int k);
        return 32'(e_src + 2 * k);
    endfunction

    function automatic logic [31:0] exp_dst(input int k);
        int r, c;
        r = k / e_wpr;
        c = k % e_wpr;
        return 32'(e_dst + (e_x / 2) * 2 * 3 + (e_y + r) * ROWB + c * 2);
    endfunction

    task automatic chk_a(input bit ok, input string req, input longint act, input longint exp);
        nchk_a++;
        if (!ok) begin
            nfail_a++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_b(input bit ok, input string req, input longint act, input longint exp);
        nchk_b++;
        if (!ok) begin
            nfail_b++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model and transaction monitor
    always @(negedge clk) begin
        if (rst) begin
            mem_ready  = 1'b0;
            status_clr = 1'b0;
        end else begin
            bit coll_now;
            coll_now = 0;
            if (done_pulse) begin
                // R8 pulse only right after the final write, run low, done set
                chk_b(pend_pulse && !run && done, "R8 pulse", {run, done}, 2'b01);
                chk_b(wr_idx == e_total, "R6 R4 word count", wr_idx, e_total);
            end else if (pend_pulse) begin
                chk_b(0, "R8 missing pulse", 0, 1);
            end
            pend_pulse = 0;
            if (!run) begin
                rd_idx = 0;
                wr_idx = 0;
            end
            mem_ready = ($urandom % 4) != 0;
            if (mem_req && mem_ready) begin
                if (!mem_we) begin
                    chk_b(rd_idx == wr_idx && rd_idx < e_total, "R12 read order", rd_idx, wr_idx);
                    chk_b(mem_addr == exp_src(rd_idx), "R6 src addr", mem_addr, exp_src(rd_idx));
                    mem_rdata = word_of(mem_addr);
                    rd_idx++;
                end else begin
                    chk_b(rd_idx == wr_idx + 1 && wr_idx < e_total, "R12 write order", rd_idx, wr_idx);
                    if (wr_idx == 0)
                        chk_b(mem_addr == exp_dst(0), "R3 dst start", mem_addr, exp_dst(0));
                    else if (wr_idx % e_wpr == 0)
                        chk_b(mem_addr == exp_dst(wr_idx), "R5 row skip", mem_addr, exp_dst(wr_idx));
                    else
                        chk_b(mem_addr == exp_dst(wr_idx), "R4 row step", mem_addr, exp_dst(wr_idx));
                    chk_b(mem_wdata == word_of(exp_src(wr_idx)), "R7 data", mem_wdata,
                          word_of(exp_src(wr_idx)));
                    if (wr_idx == e_total - 1) begin
                        pend_pulse = 1;
                        coll_now   = collide_en;
                    end
                    wr_idx++;
                end
            end
            status_clr = clr_cmd | coll_now;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_status;
        clr_cmd = 1;
        tick(2);
        clr_cmd = 0;
        tick(2);
        // R10 plain clear
        chk_a(!done && !error, "R10 clear", {done, error}, 2'b00);
    endtask

    task automatic arm(input int s, input int d, input int x, input int y, input int w, input int h);
        cfg_src_base = 32'(s);
        cfg_dst_base = 32'(d);
        cfg_x = 9'(x); cfg_y = 9'(y); cfg_width = 9'(w); cfg_height = 9'(h);
        src_arm = 1;
        tick(1);
        src_arm = 0;
        // scramble inputs: configuration must have been captured
        cfg_src_base = 32'hDEAD_0000; cfg_dst_base = '1;
        cfg_x = 9'd311; cfg_y = 9'd1; cfg_width = 9'd7; cfg_height = 9'd0;
        tick(2);
    endtask

    task automatic do_copy(input int s, input int d, input int x, input int y,
                           input int w, input int h, input bit coll);
        int guard;
        e_src = s; e_dst = d; e_x = x; e_y = y;
        e_wpr = w * 3 / 2; e_total = e_wpr * h;
        collide_en = coll;
        arm(s, d, x, y, w, h);
        dst_go = 1;
        tick(1);
        dst_go = 0;
        chk_a(run == 1'b1, "R8 run rises", run, 1);
        guard = 0;
        while (run && guard < 20000) begin
            tick(1);
            guard++;
        end
        tick(1);
        chk_a(done && !run, "R8 done latched", {done, run}, 2'b10);
        collide_en = 0;
    endtask

    task automatic do_bad(input int x, input int y, input int w, input int h);
        e_total = 0; e_wpr = 1;
        arm(32'h100, 32'h8000, x, y, w, h);
        dst_go = 1;
        tick(1);
        dst_go = 0;
        chk_a(error && !run && !mem_req, "R9 reject", {error, run, mem_req}, 3'b100);
        tick(3);
        chk_a(!run && !mem_req, "R9 no transfer", {run, mem_req}, 2'b00);
        clear_status();
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'd4711));
        e_wpr = 1; e_total = 0;
        tick(5);
        rst = 0;
        tick(1);
        chk_a({run, done, done_pulse, error, mem_req} == 5'b0, "R1 reset",
              {run, done, done_pulse, error, mem_req}, 0);

        // R2 go without arm
        dst_go = 1;
        tick(1);
        dst_go = 0;
        tick(3);
        chk_a(!run && !mem_req, "R2 ignored go", {run, mem_req}, 0);

        // directed geometries
        do_copy(32'h0001_0000, 32'h0010_0000, 5, 0, 4, 2, 0);      // odd x rounds down
        clear_status();
        do_copy(32'h0002_0000, 32'h0020_0000, 0, 238, 320, 2, 0);  // full rows, bottom edge
        clear_status();
        do_copy(32'h0003_0000, 32'h0030_0000, 300, 10, 20, 1, 0);  // right edge exactly
        // R10 collision: done already set, clear lands with final write
        do_copy(32'h0004_0000, 32'h0040_0000, 7, 3, 2, 1, 1);
        chk_a(done, "R10 set beats clear", done, 1);
        clear_status();

        // rejected geometries
        do_bad(0, 0, 3, 2);
        do_bad(302, 0, 20, 1);
        do_bad(0, 238, 4, 3);
        do_bad(0, 0, 0, 2);
        do_bad(0, 0, 4, 0);

        // constrained random copies
        for (int i = 0; i < 10; i++) begin
            int w, h, x, y;
            w = 2 * (1 + int'($urandom % 10));
            h = 1 + int'($urandom % 5);
            x = int'($urandom % (322 - w));
            y = int'($urandom % (241 - h));
            do_copy(int'($urandom & 32'h00FF_FFFE), 32'h0100_0000, x, y, w, h, (i % 3) == 0);
            clear_status();
        end

        $display("End of test - %0d assertions evaluated, %0d failures",
                 nchk_a + nchk_b, nfail_a + nfail_b);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures",
                     nchk_a + nchk_b + 1, nfail_a + nfail_b + 1);
            $finish;
        end
    end

endmodule